// File: doc/BRIEF.md
# DES Unit Mode and Key Control

This block is the configuration and sequencing front end of a DES / triple-DES cipher engine. A register port holds the operating mode, a key length in bytes and three 64-bit keys. The port can write every register and read it back. The cipher datapath itself is outside this block. So are the chaining IV and the data buffering.

When software raises `start`, the block checks the key length against the selected algorithm. If the length is wrong, or if any error is already pending, the job is refused. Otherwise `busy` rises and the block walks through the passes: one for single DES, three for triple DES. On each pass it presents the key to use and whether that pass encrypts or decrypts. The datapath signals the end of each pass with `pass_done`.

Configuration faults are latched in sticky status bits, which are cleared by writing ones to them. There are three faults: reserved mode bits written as one, a mode write during a job, and a bad key length.

Top module: `des_mode_key_ctrl`

## Requirements
- R1: After reset or a one-cycle `init` pulse, the mode register reads 0, `irq_status` is 0 and `busy` is low.
- R2: A mode write (address 0) with bits 63:3 all zero stores bits 2:0. Bit 0 selects encrypt (1) or decrypt (0), bit 1 selects triple (1) or single (0) DES, and bit 2 selects CBC (1) or ECB (0). The stored value reads back on `rd_data`, and `cbc_mode` follows bit 2.
- R3: A mode write while idle with any of bits 63:3 set sets `irq_status[1]` (data error) and leaves the mode register unchanged.
- R4: A mode write while `busy` is high sets `irq_status[2]` (context error) and leaves the mode register unchanged.
- R5: In single-DES mode, `start` with a key size register (address 1) other than 8 sets `irq_status[0]` (key size error), and `busy` stays low.
- R6: In triple-DES mode, key sizes 16 and 24 are accepted. Any other value sets `irq_status[0]` at `start`.
- R7: A write to key 1 (address 2) also loads key 3 (address 4). A write to key 3 changes only key 3. Key 2 is at address 3.
- R8: Triple-DES encryption runs three passes: key 1 encrypt, then key 2 decrypt, then key 3 encrypt.
- R9: Triple-DES decryption runs three passes: key 3 decrypt, then key 2 encrypt, then key 1 decrypt.
- R10: Single DES runs one pass with key 1, in the direction that mode bit 0 selects.
- R11: While any `irq_status` bit is set, `start` is refused and `busy` stays low.
- R12: Status bits stay set until a write to address 5 with a one in the same bit position. Zeros in that write leave the bits alone.
- R13: `busy` goes low on the clock edge that samples `pass_done` on the final pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous re-initialization, clears all state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Register read data, combinational |
| start | input | 1 | Request to begin a job |
| pass_done | input | 1 | Datapath has finished the current pass |
| busy | output | 1 | Job in progress |
| pass_idx | output | 2 | Index of the current pass |
| pass_key | output | 64 | Key for the current pass |
| pass_encrypt | output | 1 | 1 if the current pass encrypts, 0 if it decrypts |
| cbc_mode | output | 1 | Chaining mode, 1 for CBC |
| irq_status | output | 3 | Sticky errors: bit 0 key size, bit 1 data, bit 2 context |

## Verification
A wrong pass counter or key selection shows up on `pass_key` and `pass_encrypt` in the same cycle as the faulty pass. A counter that stops at the wrong pass shows up as `busy` dropping early or late, within one cycle of the last `pass_done`. A mode register that took a rejected write shows up at the next read and on `cbc_mode`. A status bit that was not latched, or that was lost, appears on `irq_status` one cycle after the offending write or `start`.

// File: rtl/des_mode_key_ctrl.sv
module des_mode_key_ctrl #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 3,
  parameter int KS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              start,
  input  logic              pass_done,
  output logic              busy,
  output logic [1:0]        pass_idx,
  output logic [DATA_W-1:0] pass_key,
  output logic              pass_encrypt,
  output logic              cbc_mode,
  output logic [2:0]        irq_status
);
  localparam logic [ADDR_W-1:0] A_MODE = 0;
  localparam logic [ADDR_W-1:0] A_KSZ  = 1;
  localparam logic [ADDR_W-1:0] A_K1   = 2;
  localparam logic [ADDR_W-1:0] A_K2   = 3;
  localparam logic [ADDR_W-1:0] A_K3   = 4;
  localparam logic [ADDR_W-1:0] A_STAT = 5;

  logic [2:0]        mode_q;
  logic [KS_W-1:0]   ksize_q;
  logic [DATA_W-1:0] key1_q, key2_q, key3_q;
  logic [2:0]        stat_q;
  logic              busy_q;
  logic [1:0]        pass_q;

  wire triple = mode_q[1];
  wire enc    = mode_q[0];
  wire [1:0] last_pass = triple ? 2'd2 : 2'd0;
  wire ks_ok = triple ? (ksize_q == KS_W'(16) || ksize_q == KS_W'(24))
                      : (ksize_q == KS_W'(8));

  wire wr_mode = wr_en && wr_addr == A_MODE;
  wire ctx_hit = wr_mode && busy_q;
  wire dat_hit = wr_mode && !busy_q && (|wr_data[DATA_W-1:3]);
  wire ks_hit  = start && !busy_q && !ks_ok;
  wire launch  = start && !busy_q && ks_ok && stat_q == 3'b000 && !dat_hit;
  wire [2:0] clr = (wr_en && wr_addr == A_STAT) ? wr_data[2:0] : 3'b000;
  wire [2:0] stat_d = (stat_q & ~clr) | {ctx_hit, dat_hit, ks_hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ksize_q <= '0;
      key1_q  <= '0;
      key2_q  <= '0;
      key3_q  <= '0;
      stat_q  <= '0;
      busy_q  <= 1'b0;
      pass_q  <= '0;
    end else if (init) begin
      mode_q  <= '0;
      ksize_q <= '0;
      key1_q  <= '0;
      key2_q  <= '0;
      key3_q  <= '0;
      stat_q  <= '0;
      busy_q  <= 1'b0;
      pass_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_mode && !busy_q && !dat_hit) mode_q <= wr_data[2:0];
      if (wr_en && wr_addr == A_KSZ) ksize_q <= wr_data[KS_W-1:0];
      if (wr_en && wr_addr == A_K1) begin
        key1_q <= wr_data;
        key3_q <= wr_data;
      end
      if (wr_en && wr_addr == A_K2) key2_q <= wr_data;
      if (wr_en && wr_addr == A_K3) key3_q <= wr_data;
      if (launch) begin
        busy_q <= 1'b1;
        pass_q <= '0;
      end else if (busy_q && pass_done) begin
        if (pass_q == last_pass) begin
          busy_q <= 1'b0;
          pass_q <= '0;
        end else begin
          pass_q <= pass_q + 2'd1;
        end
      end
    end
  end

  wire [1:0] key_sel = !triple ? 2'd0 : (enc ? pass_q : 2'd2 - pass_q);

  always_comb begin
    case (key_sel)
      2'd1:    pass_key = key2_q;
      2'd2:    pass_key = key3_q;
      default: pass_key = key1_q;
    endcase
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = DATA_W'(mode_q);
      A_KSZ:   rd_data = DATA_W'(ksize_q);
      A_K1:    rd_data = key1_q;
      A_K2:    rd_data = key2_q;
      A_K3:    rd_data = key3_q;
      A_STAT:  rd_data = DATA_W'(stat_q);
      default: rd_data = '0;
    endcase
  end

  assign pass_encrypt = triple ? (enc ^ pass_q[0]) : enc;
  assign cbc_mode     = mode_q[2];
  assign busy         = busy_q;
  assign pass_idx     = pass_q;
  assign irq_status   = stat_q;
endmodule

module des_mode_key_ctrl_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              start,
  input logic              pass_done,
  input logic              busy,
  input logic [1:0]        pass_idx,
  input logic [2:0]        irq_status,
  input logic [2:0]        mode_q,
  input logic [DATA_W-1:0] key3_q
);
  wire last = mode_q[1] ? (pass_idx == 2'd2) : (pass_idx == 2'd0);

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pass_done && last && !start |=> !busy); // R13
  AST_CTX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !init && wr_en && wr_addr == 3'd0 |=> irq_status[2]); // R4
  AST_CTX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !init && wr_en && wr_addr == 3'd0 |=> $stable(mode_q)); // R4
  AST_DATA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !init && wr_en && wr_addr == 3'd0 && (|wr_data[DATA_W-1:3]) |=> irq_status[1]); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[0] && !init && !(wr_en && wr_addr == 3'd5 && wr_data[0]) |=> irq_status[0]); // R12
  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !init && (|irq_status) |=> !busy); // R11
  AST_KEY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !init && wr_addr == 3'd2 |=> key3_q == $past(wr_data)); // R7
endmodule

bind des_mode_key_ctrl des_mode_key_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .start(start), .pass_done(pass_done), .busy(busy),
  .pass_idx(pass_idx), .irq_status(irq_status), .mode_q(mode_q), .key3_q(key3_q)
);

// File: tb/test_des_mode_key_ctrl.sv
module test_des_mode_key_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, pass_done = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data, pass_key;
  logic busy, pass_encrypt, cbc_mode;
  logic [1:0] pass_idx;
  logic [2:0] irq_status;
  int n_chk = 0, n_bad = 0;

  localparam logic [63:0] KA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] KB = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] KC = 64'h1111_2222_3333_4444;

  always #4 clk = ~clk;

  des_mode_key_ctrl i_des_mode_key_ctrl (
    .clk(clk), .rst_n(rst_n), .init(init), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .start(start),
    .pass_done(pass_done), .busy(busy), .pass_idx(pass_idx), .pass_key(pass_key),
    .pass_encrypt(pass_encrypt), .cbc_mode(cbc_mode), .irq_status(irq_status)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_pass(input string req, input logic [63:0] k, input logic e, input logic last);
    chk(req, {63'd0, busy}, 64'd1);
    chk(req, pass_key, k);
    chk(req, {63'd0, pass_encrypt}, {63'd0, e});
    pass_done = 1'b1;
    @(negedge clk); pass_done = 1'b0;
    if (last) chk("R13", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(3'd0, v); chk("R1", v, 64'd0);
    chk("R1", {61'd0, irq_status}, 64'd0);
    chk("R1", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_mode();
    logic [63:0] v;
    wr(3'd0, 64'd5);
    rd(3'd0, v); chk("R2", v, 64'd5);
    chk("R2", {63'd0, cbc_mode}, 64'd1);
    wr(3'd0, 64'h100 | 64'd3);
    chk("R3", {61'd0, irq_status}, 64'd2);
    rd(3'd0, v); chk("R3", v, 64'd5);
    wr(3'd5, 64'd0);
    chk("R12", {61'd0, irq_status}, 64'd2);
    wr(3'd5, 64'd2);
    chk("R12", {61'd0, irq_status}, 64'd0);
  endtask

  task automatic t_keys();
    logic [63:0] v;
    wr(3'd2, KA);
    rd(3'd4, v); chk("R7", v, KA);
    wr(3'd4, KC);
    rd(3'd2, v); chk("R7", v, KA);
    rd(3'd4, v); chk("R7", v, KC);
    wr(3'd3, KB);
  endtask

  task automatic t_single();
    wr(3'd0, 64'd1); wr(3'd1, 64'd8);
    go(); do_pass("R10", KA, 1'b1, 1'b1);
    wr(3'd0, 64'd0);
    go(); do_pass("R10", KA, 1'b0, 1'b1);
    wr(3'd1, 64'd16);
    go();
    chk("R5", {61'd0, irq_status}, 64'd1);
    chk("R5", {63'd0, busy}, 64'd0);
    wr(3'd1, 64'd8);
    go();
    chk("R11", {63'd0, busy}, 64'd0);
    wr(3'd5, 64'd1);
    chk("R12", {61'd0, irq_status}, 64'd0);
  endtask

  task automatic t_triple();
    wr(3'd0, 64'd3); wr(3'd1, 64'd24);
    go();
    do_pass("R8", KA, 1'b1, 1'b0);
    do_pass("R8", KB, 1'b0, 1'b0);
    do_pass("R8", KC, 1'b1, 1'b1);
    wr(3'd0, 64'd2); wr(3'd1, 64'd16); wr(3'd4, KC);
    go();
    do_pass("R9", KC, 1'b0, 1'b0);
    do_pass("R9", KB, 1'b1, 1'b0);
    do_pass("R9", KA, 1'b0, 1'b1);
    wr(3'd1, 64'd20);
    go();
    chk("R6", {61'd0, irq_status}, 64'd1);
    chk("R6", {63'd0, busy}, 64'd0);
    wr(3'd5, 64'd7);
    wr(3'd1, 64'd8);
    go();
    chk("R6", {61'd0, irq_status}, 64'd1);
    wr(3'd5, 64'd7);
  endtask

  task automatic t_ctx();
    logic [63:0] v;
    wr(3'd0, 64'd3); wr(3'd1, 64'd24);
    go();
    wr(3'd0, 64'd4);
    chk("R4", {61'd0, irq_status}, 64'd4);
    rd(3'd0, v); chk("R4", v, 64'd3);
    do_pass("R8", KA, 1'b1, 1'b0);
    do_pass("R8", KB, 1'b0, 1'b0);
    do_pass("R8", KC, 1'b1, 1'b1);
  endtask

  task automatic t_init();
    logic [63:0] v;
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    rd(3'd0, v); chk("R1", v, 64'd0);
    chk("R1", {61'd0, irq_status}, 64'd0);
    chk("R1", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_keys();
    t_single();
    t_triple();
    t_ctx();
    t_init();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule